// File: doc/BRIEF.md
# Channel Frame Sync Detector

This block watches a serial stream of recovered channel bits, one bit per asserted `bit_valid`. It looks for the frame sync word and uses it to split each frame into 14-bit symbols. The sync word is 24 bits long: a one, ten zeros, a one, ten zeros, a one, and a closing zero. A 23-bit sliding window compares only the first 23 bits, so the closing bit has no effect on detection. A frame is 588 channel bits long. Each accepted sync restarts the symbol framing. Four bits follow the sync window and are skipped: the closing sync bit and three merging bits. Then come 33 symbols, each followed by three discarded merging bits. The first symbol of each frame is flagged as subcode.

A lock controller decides which syncs to trust. It has two states. In `L_HUNT` every match is accepted and restarts the framing. It moves to `L_GUARD` once three consecutive syncs arrive, each exactly one frame after the previous accepted sync. In `L_GUARD` a match is honoured only at the expected bit. At that bit the framing restarts whether or not the sync is present, so the block coasts through a lost sync. Three consecutive missing syncs return the controller to `L_HUNT`.

The symbol framer has four states. `F_IDLE` waits for a frame start. `F_LEAD` skips the lead bits. `F_SYM` collects symbol bits. `F_MERGE` drops the merging bits and then goes back to `F_SYM`, or to `F_IDLE` after the last symbol. Any frame start, in any state, sends the framer to `F_LEAD`.

Top module: `chan_frame_sync`

## Requirements
- R1: While reset is held, and on the first cycle after it, `sync_pulse`, `guarded_sync`, `symbol_valid`, `symbol` and `is_subcode` are all 0.
- R2: A sync is recognised when the last 23 valid bits, oldest first, are 1, ten 0s, 1, ten 0s, 1. The value of the bit after them does not matter. An accepted sync gives a one-cycle `sync_pulse` in the cycle after the clock edge that took its 23rd bit.
- R3: Bits are taken only on cycles with `bit_valid` high. Cycles with `bit_valid` low change nothing, and `sync_pulse` and `symbol_valid` stay 0 on them.
- R4: `guarded_sync` rises at the edge of the sync that is the third in a row spaced exactly 588 valid bits after the previous accepted sync. Any accepted sync at another spacing resets this count.
- R5: Count the 23rd sync bit as position 0. Positions 1 to 4 are skipped. Symbol k (k = 0 to 32) occupies positions 5+17k to 18+17k, and the three bits after it are discarded. `symbol_valid` pulses for one cycle after the edge that took the symbol's last bit. `symbol[13]` holds the first bit received.
- R6: `is_subcode` is 1 with the first symbol after a frame start and 0 with every other symbol.
- R7: Exactly 33 symbols are produced per frame. No `symbol_valid` follows the 33rd until the next frame start.
- R8: While guarded, a pattern match at any bit other than the expected one gives no `sync_pulse` and does not re-phase the symbol framing.
- R9: While guarded, if no sync is present at the expected bit, there is no `sync_pulse`. The framing still restarts there as if a sync had come, and `guarded_sync` stays 1 until the third consecutive miss.
- R10: `guarded_sync` falls at the edge of the third consecutive missing sync. A sync present at the expected bit resets the miss count.
- R11: While not guarded, every pattern match is accepted, pulses `sync_pulse` and restarts the symbol framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_in | input | 1 | Recovered channel bit |
| bit_valid | input | 1 | `bit_in` is taken on this cycle |
| sync_pulse | output | 1 | One-cycle pulse for an accepted sync |
| guarded_sync | output | 1 | Sync lock established |
| symbol_valid | output | 1 | One-cycle pulse, `symbol` is new |
| symbol | output | 14 | Assembled symbol, first bit received in the MSB |
| is_subcode | output | 1 | The symbol is the first one of its frame |

## Verification
A framer counter that is off by even one bit shows up as a wrong `symbol` value at the very next `symbol_valid`. A lost or spurious frame start changes the number and spacing of pulses within the same frame. A wrong lock count or miss count shows up as `guarded_sync` moving one sync early or late, or as a spurious `sync_pulse` when the off-time pattern arrives. Every such error is therefore visible at the ports within one frame of 588 bits.

// File: rtl/fsd_pkg.sv
`timescale 1ns/1ps
package fsd_pkg;

    typedef enum logic {
        L_HUNT,
        L_GUARD
    } lock_state_t;

    typedef enum logic [1:0] {
        F_IDLE,
        F_LEAD,
        F_SYM,
        F_MERGE
    } frame_state_t;

    // Marker pattern: ones at both ends and in the middle, zero runs between.
    function automatic logic [31:0] sync_pattern(input int zero_run);
        logic [31:0] p;
        p = '0;
        p[0] = 1'b1;
        p[zero_run + 1] = 1'b1;
        p[2 * zero_run + 2] = 1'b1;
        return p;
    endfunction

endpackage

// File: rtl/fsd_sync_match.sv
`timescale 1ns/1ps
module fsd_sync_match
    import fsd_pkg::*;
#(
    parameter int ZERO_RUN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_valid,
    output logic raw_match
);
    localparam int WIN = 2 * ZERO_RUN + 3;
    localparam logic [31:0] PAT_FULL = sync_pattern(ZERO_RUN);
    localparam logic [WIN-1:0] PAT = PAT_FULL[WIN-1:0];

    logic [WIN-1:0] win_q;
    logic [WIN-1:0] win_next;

    assign win_next  = {win_q[WIN-2:0], bit_in};
    assign raw_match = bit_valid && (win_next == PAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         win_q <= '0;
        else if (bit_valid) win_q <= win_next;
    end
endmodule

// File: rtl/fsd_lock_ctrl.sv
`timescale 1ns/1ps
module fsd_lock_ctrl
    import fsd_pkg::*;
#(
    parameter int FRAME_BITS = 588,
    parameter int LOCK_N     = 3,
    parameter int UNLOCK_N   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic raw_match,
    output logic frame_start,
    output logic sync_accept,
    output logic guarded
);
    localparam int CW = $clog2(FRAME_BITS + 1);
    localparam int GW = $clog2(LOCK_N + 1);
    localparam int MW = $clog2(UNLOCK_N + 1);

    lock_state_t   state_q, state_d;
    logic [CW-1:0] since_q, since_d;
    logic [GW-1:0] good_q, good_d;
    logic [MW-1:0] miss_q, miss_d;
    logic          at_exp;

    assign at_exp = bit_valid && (since_q == CW'(FRAME_BITS - 1));

    always_comb begin
        state_d     = state_q;
        good_d      = good_q;
        miss_d      = miss_q;
        frame_start = 1'b0;
        sync_accept = 1'b0;
        unique case (state_q)
            L_HUNT: begin
                if (raw_match) begin
                    frame_start = 1'b1;
                    sync_accept = 1'b1;
                    if (at_exp) begin
                        if (good_q == GW'(LOCK_N - 1)) begin
                            state_d = L_GUARD;
                            good_d  = '0;
                            miss_d  = '0;
                        end else begin
                            good_d = good_q + 1'b1;
                        end
                    end else begin
                        good_d = '0;
                    end
                end
            end
            L_GUARD: begin
                if (at_exp) begin
                    frame_start = 1'b1;
                    sync_accept = raw_match;
                    if (raw_match) begin
                        miss_d = '0;
                    end else if (miss_q == MW'(UNLOCK_N - 1)) begin
                        state_d = L_HUNT;
                        miss_d  = '0;
                        good_d  = '0;
                    end else begin
                        miss_d = miss_q + 1'b1;
                    end
                end
            end
        endcase
        if (frame_start)                      since_d = '0;
        else if (bit_valid && since_q != '1)  since_d = since_q + 1'b1;
        else                                  since_d = since_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= L_HUNT;
            since_q <= '1;
            good_q  <= '0;
            miss_q  <= '0;
        end else begin
            state_q <= state_d;
            since_q <= since_d;
            good_q  <= good_d;
            miss_q  <= miss_d;
        end
    end

    assign guarded = (state_q == L_GUARD);

    a_r4_guard_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == L_GUARD && $past(state_q) == L_HUNT) |-> $past(raw_match && at_exp));

    a_r10_guard_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == L_HUNT && $past(state_q) == L_GUARD) |-> $past(at_exp && !raw_match));

    a_r9_flywheel_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == L_GUARD) |-> (since_q < CW'(FRAME_BITS)));
endmodule

// File: rtl/fsd_symbol_framer.sv
`timescale 1ns/1ps
module fsd_symbol_framer
    import fsd_pkg::*;
#(
    parameter int SYM_BITS   = 14,
    parameter int MERGE_BITS = 3,
    parameter int LEAD_BITS  = 4,
    parameter int SYMS       = 33
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_in,
    input  logic                bit_valid,
    input  logic                frame_start,
    output logic                symbol_valid,
    output logic [SYM_BITS-1:0] symbol,
    output logic                is_subcode
);
    localparam int FMAX = (SYM_BITS > LEAD_BITS) ?
                          ((SYM_BITS > MERGE_BITS) ? SYM_BITS : MERGE_BITS) :
                          ((LEAD_BITS > MERGE_BITS) ? LEAD_BITS : MERGE_BITS);
    localparam int FW = $clog2(FMAX + 1);
    localparam int IW = $clog2(SYMS + 1);

    frame_state_t        st_q, st_d;
    logic [FW-1:0]       fc_q, fc_d;
    logic [IW-1:0]       ix_q, ix_d;
    logic [SYM_BITS-1:0] sh_q, sh_d;
    logic                emit;

    always_comb begin
        st_d = st_q;
        fc_d = fc_q;
        ix_d = ix_q;
        sh_d = sh_q;
        emit = 1'b0;
        if (bit_valid) begin
            if (frame_start) begin
                st_d = F_LEAD;
                fc_d = '0;
                ix_d = '0;
            end else begin
                unique case (st_q)
                    F_IDLE: st_d = F_IDLE;
                    F_LEAD: begin
                        if (fc_q == FW'(LEAD_BITS - 1)) begin
                            st_d = F_SYM;
                            fc_d = '0;
                        end else begin
                            fc_d = fc_q + 1'b1;
                        end
                    end
                    F_SYM: begin
                        sh_d = {sh_q[SYM_BITS-2:0], bit_in};
                        if (fc_q == FW'(SYM_BITS - 1)) begin
                            emit = 1'b1;
                            st_d = F_MERGE;
                            fc_d = '0;
                        end else begin
                            fc_d = fc_q + 1'b1;
                        end
                    end
                    F_MERGE: begin
                        if (fc_q == FW'(MERGE_BITS - 1)) begin
                            fc_d = '0;
                            if (ix_q == IW'(SYMS - 1)) begin
                                st_d = F_IDLE;
                            end else begin
                                st_d = F_SYM;
                                ix_d = ix_q + 1'b1;
                            end
                        end else begin
                            fc_d = fc_q + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= F_IDLE;
            fc_q <= '0;
            ix_q <= '0;
            sh_q <= '0;
        end else begin
            st_q <= st_d;
            fc_q <= fc_d;
            ix_q <= ix_d;
            sh_q <= sh_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            symbol_valid <= 1'b0;
            symbol       <= '0;
            is_subcode   <= 1'b0;
        end else begin
            symbol_valid <= emit;
            if (emit) begin
                symbol     <= sh_d;
                is_subcode <= (ix_q == '0);
            end
        end
    end

    a_r7_merge_gap: assert property (@(posedge clk) disable iff (!rst_n)
        symbol_valid |=> !symbol_valid);

    a_r7_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        ix_q < IW'(SYMS));
endmodule

// File: rtl/chan_frame_sync.sv
`timescale 1ns/1ps
module chan_frame_sync
    import fsd_pkg::*;
#(
    parameter int ZERO_RUN   = 10,
    parameter int FRAME_BITS = 588,
    parameter int SYM_BITS   = 14,
    parameter int MERGE_BITS = 3,
    parameter int SYMS       = 33,
    parameter int LOCK_N     = 3,
    parameter int UNLOCK_N   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_in,
    input  logic                bit_valid,
    output logic                sync_pulse,
    output logic                guarded_sync,
    output logic                symbol_valid,
    output logic [SYM_BITS-1:0] symbol,
    output logic                is_subcode
);
    // Skipped after the 23-bit window: closing sync bit plus merging bits.
    localparam int LEAD_BITS = 1 + MERGE_BITS;

    logic raw_match;
    logic frame_start;
    logic sync_accept;

    fsd_sync_match #(.ZERO_RUN(ZERO_RUN)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (bit_in),
        .bit_valid (bit_valid),
        .raw_match (raw_match)
    );

    fsd_lock_ctrl #(
        .FRAME_BITS (FRAME_BITS),
        .LOCK_N     (LOCK_N),
        .UNLOCK_N   (UNLOCK_N)
    ) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_valid   (bit_valid),
        .raw_match   (raw_match),
        .frame_start (frame_start),
        .sync_accept (sync_accept),
        .guarded     (guarded_sync)
    );

    fsd_symbol_framer #(
        .SYM_BITS   (SYM_BITS),
        .MERGE_BITS (MERGE_BITS),
        .LEAD_BITS  (LEAD_BITS),
        .SYMS       (SYMS)
    ) u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_in       (bit_in),
        .bit_valid    (bit_valid),
        .frame_start  (frame_start),
        .symbol_valid (symbol_valid),
        .symbol       (symbol),
        .is_subcode   (is_subcode)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_pulse <= 1'b0;
        else        sync_pulse <= sync_accept;
    end

    a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> !sync_pulse);

    a_r5_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> !symbol_valid);
endmodule

// File: tb/chan_frame_sync_tb.sv
`timescale 1ns/1ps
module chan_frame_sync_tb;
    localparam logic [22:0] PAT = 23'b1_0000000000_1_0000000000_1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_in = 1'b0;
    logic        bit_valid = 1'b0;
    logic        sync_pulse, guarded_sync, symbol_valid, is_subcode;
    logic [13:0] symbol;

    always #2.5 clk = ~clk;

    chan_frame_sync u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_in       (bit_in),
        .bit_valid    (bit_valid),
        .sync_pulse   (sync_pulse),
        .guarded_sync (guarded_sync),
        .symbol_valid (symbol_valid),
        .symbol       (symbol),
        .is_subcode   (is_subcode)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string phase = "R3";

    // Reference state, kept from the requirements.
    logic [31:0] hist = '0;
    int          since = 1000000;
    bit          mlock = 1'b0;
    int          good = 0;
    int          miss = 0;
    int          sym_seen = 0;
    bit          fb [0:599];

    task automatic chk_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic fill(input int a, input int b);
        int i = a;
        while (i <= b) begin
            int z;
            fb[i] = 1'b1;
            i++;
            z = 2 + int'($urandom % 7);
            for (int k = 0; k < z && i <= b; k++) begin
                fb[i] = 1'b0;
                i++;
            end
        end
    endtask

    task automatic build(input bit with_sync, input bit tail, input int fake_at, input int len);
        if (with_sync) begin
            for (int i = 0; i < 23; i++) fb[i] = PAT[22-i];
            fb[23] = tail;
            fill(24, len - 1);
        end else begin
            fill(0, len - 1);
        end
        if (fake_at > 0) begin
            for (int i = 0; i < 23; i++) fb[fake_at+i] = PAT[22-i];
            fb[fake_at+23] = 1'b1;
        end
    endtask

    task automatic send_bit(input bit b);
        bit match, at_exp, start, real_s, exp_sv;
        while ($urandom % 4 == 0) begin
            @(negedge clk);
            bit_valid = 1'b0;
            bit_in = 1'($urandom % 2);
            @(posedge clk);
            #1;
            chk_eq("R3 sync_pulse on idle cycle", sync_pulse, 0);
            chk_eq("R3 symbol_valid on idle cycle", symbol_valid, 0);
        end
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in = b;
        hist   = {hist[30:0], b};
        match  = (hist[22:0] == PAT);
        at_exp = (since == 587);
        start  = 1'b0;
        real_s = 1'b0;
        if (!mlock) begin
            if (match) begin
                start = 1'b1;
                real_s = 1'b1;
                if (at_exp) begin
                    if (good == 2) begin mlock = 1'b1; good = 0; miss = 0; end
                    else good++;
                end else good = 0;
            end
        end else if (at_exp) begin
            start = 1'b1;
            real_s = match;
            if (match) miss = 0;
            else if (miss == 2) begin mlock = 1'b0; miss = 0; good = 0; end
            else miss++;
        end
        since = start ? 0 : since + 1;
        exp_sv = !start && since >= 18 && (since - 18) % 17 == 0 && (since - 18) / 17 <= 32;
        @(posedge clk);
        #1;
        chk_eq($sformatf("R2 sync_pulse [%s]", phase), sync_pulse, int'(real_s));
        chk_eq($sformatf("R4 guarded_sync [%s]", phase), guarded_sync, int'(mlock));
        chk_eq($sformatf("R5 symbol_valid [%s]", phase), symbol_valid, int'(exp_sv));
        if (symbol_valid) sym_seen++;
        if (exp_sv) begin
            chk_eq($sformatf("R5 symbol value [%s]", phase), symbol, int'(hist[13:0]));
            chk_eq($sformatf("R6 is_subcode [%s]", phase), is_subcode, int'(since == 18));
        end
    endtask

    task automatic send_frame(input bit with_sync, input bit tail, input int fake_at, input int len);
        build(with_sync, tail, fake_at, len);
        for (int i = 0; i < len; i++) send_bit(fb[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        #1;
        chk_eq("R1 sync_pulse in reset", sync_pulse, 0);
        chk_eq("R1 guarded_sync in reset", guarded_sync, 0);
        chk_eq("R1 symbol_valid in reset", symbol_valid, 0);
        chk_eq("R1 symbol in reset", symbol, 0);
        chk_eq("R1 is_subcode in reset", is_subcode, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk_eq("R1 guarded_sync after reset", guarded_sync, 0);
        chk_eq("R1 symbol_valid after reset", symbol_valid, 0);

        phase = "R3";
        build(1'b0, 1'b0, 0, 150);
        for (int i = 0; i < 150; i++) send_bit(fb[i]);

        phase = "R11";
        send_frame(1'b1, 1'b0, 0, 590);
        send_frame(1'b1, 1'b0, 0, 588);
        send_frame(1'b1, 1'b0, 0, 588);
        send_frame(1'b1, 1'b0, 0, 585);
        chk_eq("R11 not guarded after broken spacing", guarded_sync, 0);

        phase = "R4";
        for (int f = 0; f < 4; f++) send_frame(1'b1, 1'b0, 0, 588);
        chk_eq("R4 guarded after three spaced syncs", guarded_sync, 1);

        phase = "R2";
        send_frame(1'b1, 1'b1, 0, 588);

        phase = "R8";
        sym_seen = 0;
        send_frame(1'b1, 1'b0, 250, 588);
        chk_eq("R7 symbols in one frame", sym_seen, 33);
        chk_eq("R8 guard held after off-time pattern", guarded_sync, 1);

        phase = "R9";
        sym_seen = 0;
        send_frame(1'b0, 1'b0, 0, 588);
        chk_eq("R9 symbols in coasted frame", sym_seen, 33);
        send_frame(1'b0, 1'b0, 0, 588);
        chk_eq("R9 guard held after two misses", guarded_sync, 1);
        send_frame(1'b1, 1'b0, 0, 588);

        phase = "R10";
        for (int f = 0; f < 3; f++) send_frame(1'b0, 1'b0, 0, 588);
        send_bit(1'b1);
        chk_eq("R10 guard dropped after three misses", guarded_sync, 0);
        phase = "R11";
        send_frame(1'b1, 1'b0, 0, 588);
        send_frame(1'b1, 1'b0, 0, 588);

        build(1'b0, 1'b0, 0, 100);
        for (int i = 0; i < 100; i++) send_bit(fb[i]);
        @(negedge clk);
        bit_valid = 1'b0;
        @(posedge clk);
        #1;
        chk_eq("R3 no pulse after stream stops", symbol_valid, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule